// File: doc/BRIEF.md
# ATM Control Cell Filter

This block sits on a nibble-wide cell input. Each cell is 53 bytes long and arrives as 106 nibbles. A start-of-cell flag travels with the first nibble, and within each byte the high nibble comes first. The block checks the header of every cell against a control-cell identifier that software can program.

A cell that matches is a control cell. It is removed from the forwarded stream. Its command byte and its two parameter bytes are handed to a command executor as a one-cycle pulse. Every other cell is sent out on a byte-wide port, unchanged and in order, with a start flag on its first byte.

Each incoming cell is written into one of two cell slots of an inferable RAM. A cell is only replayed to the output once all 53 bytes have arrived and the cell has been judged a non-control cell. As a result, a cell cut short by an early start-of-cell flag never leaks out. The executor reports that it is still working through a busy input. A control cell that completes while busy is high is dropped.

Top module: `ctl_cell_filter`

## Requirements
- R1: A cell is a control cell when the low nibble of byte 0 is 0, byte 1 is 0x00, and byte 2 equals the control identifier. Byte 0 low nibble and byte 1 high nibble hold the path identifier. Byte 1 low nibble holds the top four channel-identifier bits. The control identifier is 0x1F after reset.
- R2: The high nibble of byte 0, all of byte 3 and byte 4 have no effect on the match.
- R3: A non-control cell appears on `out_byte` as all 53 bytes in arrival order, one per `out_valid` cycle. `out_soc` is high with byte 0 only.
- R4: A control cell produces no `out_valid` bytes.
- R5: Each accepted control cell raises `cmd_valid` for exactly one cycle after its last byte. At that time `cmd_code` holds byte 5, `cmd_arg_a` holds byte 6 and `cmd_arg_b` holds byte 7.
- R6: If `cmd_busy` is high when a control cell completes, the cell is dropped: no `cmd_valid` is raised and nothing is forwarded.
- R7: Writing `cfg_ctl_id` with `cfg_we` replaces the control identifier for cells that arrive afterwards.
- R8: Nibbles are taken only when `in_valid` is high, so idle cycles inside a cell do not change the result.
- R9: A start-of-cell flag that arrives before the current cell is complete discards the unfinished cell, and a new cell begins with that nibble.
- R10: While reset is held and in the cycle after it, `out_valid` and `cmd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Nibble strobe |
| in_soc | input | 1 | First nibble of a cell |
| in_nib | input | 4 | Cell data nibble, high half of each byte first |
| cfg_we | input | 1 | Write strobe for the control identifier |
| cfg_ctl_id | input | 8 | New control identifier |
| cmd_busy | input | 1 | Executor still working on the previous command |
| out_valid | output | 1 | Forwarded byte valid |
| out_soc | output | 1 | Forwarded byte is byte 0 of a cell |
| out_byte | output | 8 | Forwarded cell byte |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_code | output | 8 | Command byte |
| cmd_arg_a | output | 8 | First parameter byte |
| cmd_arg_b | output | 8 | Second parameter byte |

## Verification
The assertions rely on a few assumptions about the input. Complete cells are taken to be at least 106 input cycles apart, which makes replay of one slot finish before the next cell completes. This also keeps `cmd_valid` pulses far apart and keeps forwarded cells from overlapping. The executor's busy line is assumed to follow only its own command activity. The stimulus respects all of this. It drives nibbles one per cycle or with idle cycles in between, cuts cells short only with a fresh start flag, and changes busy and the identifier only between cells.

// File: rtl/ccf_pkg.sv
package ccf_pkg;
  localparam int CELL_BYTES = 53;
  localparam int IDX_W      = $clog2(CELL_BYTES);
  localparam int NIB_W      = 4;
  localparam int BYTE_W     = 2 * NIB_W;
  // header and payload byte positions the decoder depends on
  localparam int POS_PATH   = 0;
  localparam int POS_CHAN_H = 1;
  localparam int POS_CHAN_M = 2;
  localparam int POS_CODE   = 5;
  localparam int POS_ARG_A  = 6;
  localparam int POS_ARG_B  = 7;

  typedef struct packed {
    logic [BYTE_W-1:0] code;
    logic [BYTE_W-1:0] arg_a;
    logic [BYTE_W-1:0] arg_b;
  } ccf_cmd_t;
endpackage

// File: rtl/ccf_nib_assemble.sv
module ccf_nib_assemble
  import ccf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              nib_valid,
  input  logic              nib_soc,
  input  logic [NIB_W-1:0]  nib,
  output logic              byte_valid,
  output logic [IDX_W-1:0]  byte_idx,
  output logic [BYTE_W-1:0] byte_data,
  output logic              byte_last
);
  logic             in_cell;
  logic             half;
  logic [IDX_W-1:0] idx;
  logic [NIB_W-1:0] hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_cell    <= 1'b0;
      half       <= 1'b0;
      idx        <= '0;
      hi         <= '0;
      byte_valid <= 1'b0;
      byte_idx   <= '0;
      byte_data  <= '0;
      byte_last  <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      byte_last  <= 1'b0;
      if (nib_valid) begin
        if (nib_soc) begin
          // a fresh start always wins; any unfinished cell is abandoned
          in_cell <= 1'b1;
          half    <= 1'b1;
          idx     <= '0;
          hi      <= nib;
        end else if (in_cell) begin
          if (half) begin
            byte_valid <= 1'b1;
            byte_idx   <= idx;
            byte_data  <= {hi, nib};
            half       <= 1'b0;
            if (idx == IDX_W'(CELL_BYTES - 1)) begin
              byte_last <= 1'b1;
              in_cell   <= 1'b0;
            end else begin
              idx <= idx + 1'b1;
            end
          end else begin
            hi   <= nib;
            half <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ccf_hdr_match.sv
module ccf_hdr_match
  import ccf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_valid,
  input  logic [IDX_W-1:0]  byte_idx,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              byte_last,
  input  logic [BYTE_W-1:0] ctl_id,
  output logic              dec_valid,
  output logic              dec_ctl,
  output ccf_cmd_t          dec_cmd
);
  logic     hit;
  ccf_cmd_t cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      hit       <= 1'b0;
      cap       <= '0;
      dec_valid <= 1'b0;
      dec_ctl   <= 1'b0;
      dec_cmd   <= '0;
    end else begin
      dec_valid <= 1'b0;
      if (byte_valid) begin
        case (int'(byte_idx))
          POS_PATH:   hit <= (byte_data[NIB_W-1:0] == '0);
          POS_CHAN_H: hit <= hit && (byte_data == '0);
          POS_CHAN_M: hit <= hit && (byte_data == ctl_id);
          POS_CODE:   cap.code  <= byte_data;
          POS_ARG_A:  cap.arg_a <= byte_data;
          POS_ARG_B:  cap.arg_b <= byte_data;
          default: ;
        endcase
        if (byte_last) begin
          dec_valid <= 1'b1;
          dec_ctl   <= hit;
          dec_cmd   <= cap;
        end
      end
    end
  end
endmodule

// File: rtl/ccf_replay_buf.sv
module ccf_replay_buf
  import ccf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_valid,
  input  logic [IDX_W-1:0]  byte_idx,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              dec_valid,
  input  logic              dec_ctl,
  output logic              out_valid,
  output logic              out_soc,
  output logic [BYTE_W-1:0] out_byte
);
  localparam int ADDR_W = IDX_W + 1;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic              wr_slot;
  logic              rd_slot;
  logic              rd_act;
  logic [IDX_W-1:0]  rd_idx;

  // plain write port and registered read port for block RAM inference
  always_ff @(posedge clk) begin
    if (byte_valid) mem[{wr_slot, byte_idx}] <= byte_data;
    out_byte <= mem[{rd_slot, rd_idx}];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_slot   <= 1'b0;
      rd_slot   <= 1'b0;
      rd_act    <= 1'b0;
      rd_idx    <= '0;
      out_valid <= 1'b0;
      out_soc   <= 1'b0;
    end else begin
      out_valid <= rd_act;
      out_soc   <= rd_act && (rd_idx == '0);
      if (rd_act) begin
        if (rd_idx == IDX_W'(CELL_BYTES - 1)) begin
          rd_act <= 1'b0;
          rd_idx <= '0;
        end else begin
          rd_idx <= rd_idx + 1'b1;
        end
      end
      if (dec_valid && !dec_ctl) begin
        rd_act  <= 1'b1;
        rd_idx  <= '0;
        rd_slot <= wr_slot;
        wr_slot <= ~wr_slot;
      end
    end
  end
endmodule

// File: rtl/ctl_cell_filter.sv
module ctl_cell_filter
  import ccf_pkg::*;
#(
  parameter logic [7:0] CTL_ID_RST = 8'h1F
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic       in_soc,
  input  logic [3:0] in_nib,
  input  logic       cfg_we,
  input  logic [7:0] cfg_ctl_id,
  input  logic       cmd_busy,
  output logic       out_valid,
  output logic       out_soc,
  output logic [7:0] out_byte,
  output logic       cmd_valid,
  output logic [7:0] cmd_code,
  output logic [7:0] cmd_arg_a,
  output logic [7:0] cmd_arg_b
);
  logic              bv;
  logic [IDX_W-1:0]  bidx;
  logic [BYTE_W-1:0] bdata;
  logic              blast;
  logic              dv;
  logic              dctl;
  ccf_cmd_t          dcmd;
  logic [7:0]        ctl_id;

  always_ff @(posedge clk) begin
    if (rst)         ctl_id <= CTL_ID_RST;
    else if (cfg_we) ctl_id <= cfg_ctl_id;
  end

  ccf_nib_assemble u_asm (
    .clk(clk), .rst(rst), .nib_valid(in_valid), .nib_soc(in_soc), .nib(in_nib),
    .byte_valid(bv), .byte_idx(bidx), .byte_data(bdata), .byte_last(blast)
  );

  ccf_hdr_match u_match (
    .clk(clk), .rst(rst), .byte_valid(bv), .byte_idx(bidx), .byte_data(bdata),
    .byte_last(blast), .ctl_id(ctl_id),
    .dec_valid(dv), .dec_ctl(dctl), .dec_cmd(dcmd)
  );

  ccf_replay_buf u_buf (
    .clk(clk), .rst(rst), .byte_valid(bv), .byte_idx(bidx), .byte_data(bdata),
    .dec_valid(dv), .dec_ctl(dctl),
    .out_valid(out_valid), .out_soc(out_soc), .out_byte(out_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      cmd_code  <= '0;
      cmd_arg_a <= '0;
      cmd_arg_b <= '0;
    end else begin
      cmd_valid <= 1'b0;
      if (dv && dctl && !cmd_busy) begin
        cmd_valid <= 1'b1;
        cmd_code  <= dcmd.code;
        cmd_arg_a <= dcmd.arg_a;
        cmd_arg_b <= dcmd.arg_b;
      end
    end
  end
endmodule

// File: rtl/ctl_cell_filter_chk.sv
module ctl_cell_filter_chk (
  input logic clk,
  input logic rst,
  input logic out_valid,
  input logic out_soc,
  input logic cmd_valid,
  input logic cmd_busy
);
  logic [6:0] ocnt;

  always_ff @(posedge clk) begin
    if (rst)                       ocnt <= '0;
    else if (out_valid && out_soc) ocnt <= 7'd1;
    else if (out_valid)            ocnt <= ocnt + 7'd1;
  end

  assert_cmd_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

  assert_busy_drop_R6: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !$past(cmd_busy));

  assert_soc_with_valid_R3: assert property (@(posedge clk) disable iff (rst)
    out_soc |-> out_valid);

  assert_cell_start_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_soc) |-> (ocnt == 7'd0 || ocnt == 7'd53));

  assert_cell_length_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_soc) |-> (ocnt != 7'd0 && ocnt < 7'd53));

  assert_reset_quiet_R10: assert property (@(posedge clk)
    rst |=> (!out_valid && !cmd_valid));
endmodule

bind ctl_cell_filter ctl_cell_filter_chk i_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_soc(out_soc),
  .cmd_valid(cmd_valid), .cmd_busy(cmd_busy)
);

// File: tb/test_ctl_cell_filter.sv
module test_ctl_cell_filter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0, in_soc = 1'b0;
  logic [3:0] in_nib = '0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_ctl_id = '0;
  logic       cmd_busy = 1'b0;
  logic       out_valid, out_soc, cmd_valid;
  logic [7:0] out_byte, cmd_code, cmd_arg_a, cmd_arg_b;

  int checks = 0, errors = 0;
  logic [7:0] oq[$];
  int soc_cnt = 0, soc_bad = 0, cmd_cnt = 0;
  logic [7:0] l_code, l_a, l_b;

  always #5 clk = ~clk;

  ctl_cell_filter i_ctl_cell_filter (.*);

  // fields: byte0, byte1, byte2, byte3, command, expect forwarded
  localparam logic [40:0] VEC [8] = '{
    {8'h00, 8'h00, 8'h20, 8'h00, 8'h10, 1'b1},  // R1 channel byte differs
    {8'h00, 8'h00, 8'h1F, 8'h00, 8'h11, 1'b0},  // R1 plain control
    {8'hF0, 8'h00, 8'h1F, 8'hFF, 8'h22, 1'b0},  // R2 ignored fields set
    {8'h01, 8'h00, 8'h1F, 8'h00, 8'h33, 1'b1},  // R1 path high nibble
    {8'h00, 8'h10, 8'h1F, 8'h00, 8'h44, 1'b1},  // R1 path low nibble
    {8'h00, 8'h01, 8'h1F, 8'h00, 8'h55, 1'b1},  // R1 channel top bits
    {8'h00, 8'h00, 8'h1E, 8'h00, 8'h66, 1'b1},  // R1 off by one
    {8'h50, 8'h00, 8'h1F, 8'h0E, 8'h7E, 1'b0}   // R2 control again
  };

  function automatic logic [7:0] cb(logic [7:0] b0, b1, b2, b3, cmd, int i);
    case (i)
      0: return b0;
      1: return b1;
      2: return b2;
      3: return b3;
      4: return 8'hA5;
      5: return cmd;
      6: return cmd ^ 8'h3C;
      7: return cmd + 8'd1;
      8: return 8'h00;
      default: return 8'(i) ^ cmd;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b0, b1, b2, b3, cmd, input int nnib, input bit gaps);
    for (int i = 0; i < nnib; i++) begin
      logic [7:0] bt;
      bt = cb(b0, b1, b2, b3, cmd, i / 2);
      @(negedge clk);
      in_valid = 1'b1;
      in_soc   = (i == 0);
      in_nib   = (i % 2 == 0) ? bt[7:4] : bt[3:0];
      if (gaps && (i % 3 == 1)) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_soc   = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_soc   = 1'b0;
  endtask

  task automatic clear_mon();
    oq.delete();
    soc_cnt = 0;
    soc_bad = 0;
  endtask

  task automatic expect_fwd(input logic [7:0] b0, b1, b2, b3, cmd, input string req);
    int bad = 0;
    chk(oq.size() == 53, req, oq.size(), 53);
    if (oq.size() == 53)
      for (int i = 0; i < 53; i++)
        if (oq[i] !== cb(b0, b1, b2, b3, cmd, i)) bad++;
    chk(bad == 0, req, bad, 0);
    chk(soc_cnt == 1 && soc_bad == 0, req, soc_cnt, 1);
  endtask

  task automatic run_cell(input logic [7:0] b0, b1, b2, b3, cmd,
                          input bit exp_fwd, input bit exp_cmd, input bit gaps,
                          input string req);
    int c0;
    clear_mon();
    c0 = cmd_cnt;
    send(b0, b1, b2, b3, cmd, 106, gaps);
    repeat (80) @(negedge clk);
    if (exp_fwd) expect_fwd(b0, b1, b2, b3, cmd, req);
    else chk(oq.size() == 0, {req, " no forward"}, oq.size(), 0);
    chk(cmd_cnt == c0 + (exp_cmd ? 1 : 0), {req, " cmd count"}, cmd_cnt - c0, exp_cmd ? 1 : 0);
    if (exp_cmd) begin
      chk(l_code == cmd, {req, " code"}, l_code, cmd);
      chk(l_a == (cmd ^ 8'h3C), {req, " arg a"}, l_a, cmd ^ 8'h3C);
      chk(l_b == cmd + 8'd1, {req, " arg b"}, l_b, cmd + 8'd1);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        oq.push_back(out_byte);
        if (out_soc) begin
          soc_cnt++;
          if (oq.size() % 53 != 1) soc_bad++;
        end
      end
      if (cmd_valid) begin
        cmd_cnt++;
        l_code = cmd_code;
        l_a    = cmd_arg_a;
        l_b    = cmd_arg_b;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int c0;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0 && cmd_valid == 1'b0, "R10 during reset", out_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0 && cmd_valid == 1'b0, "R10 after reset", cmd_valid, 0);

    // table walk
    foreach (VEC[k]) begin
      logic [40:0] v;
      v = VEC[k];
      run_cell(v[40:33], v[32:25], v[24:17], v[16:9], v[8:1], v[0], !v[0], 1'b0,
               v[0] ? "R3 table forward" : "R4 R5 table control");
    end

    // R8: idle cycles inside cells
    run_cell(8'h00, 8'h00, 8'h40, 8'h00, 8'h90, 1'b1, 1'b0, 1'b1, "R8 gapped data");
    run_cell(8'h00, 8'h00, 8'h1F, 8'h00, 8'h91, 1'b0, 1'b1, 1'b1, "R8 gapped control");

    // R6: busy executor drops the command
    cmd_busy = 1'b1;
    run_cell(8'h00, 8'h00, 8'h1F, 8'h00, 8'hA1, 1'b0, 1'b0, 1'b0, "R6 busy drop");
    cmd_busy = 1'b0;
    run_cell(8'h00, 8'h00, 8'h1F, 8'h00, 8'hA2, 1'b0, 1'b1, 1'b0, "R6 idle accept");

    // R7: reprogrammed identifier
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_ctl_id = 8'h2A;
    @(negedge clk);
    cfg_we = 1'b0;
    run_cell(8'h00, 8'h00, 8'h1F, 8'h00, 8'hB1, 1'b1, 1'b0, 1'b0, "R7 old id forwarded");
    run_cell(8'h00, 8'h00, 8'h2A, 8'h00, 8'hB2, 1'b0, 1'b1, 1'b0, "R7 new id control");

    // R9: truncated control cell then a truncated data cell, then a full data cell
    clear_mon();
    c0 = cmd_cnt;
    send(8'h00, 8'h00, 8'h2A, 8'h00, 8'hC1, 20, 1'b0);
    send(8'h00, 8'h00, 8'h70, 8'h00, 8'hC2, 60, 1'b0);
    send(8'h00, 8'h00, 8'h71, 8'h00, 8'hC3, 106, 1'b0);
    repeat (80) @(negedge clk);
    expect_fwd(8'h00, 8'h00, 8'h71, 8'h00, 8'hC3, "R9 truncation");
    chk(cmd_cnt == c0, "R9 truncated control silent", cmd_cnt - c0, 0);

    // R3: two data cells back to back
    clear_mon();
    send(8'h00, 8'h00, 8'h01, 8'h00, 8'hD1, 106, 1'b0);
    send(8'h00, 8'h00, 8'h02, 8'h00, 8'hD2, 106, 1'b0);
    repeat (80) @(negedge clk);
    chk(oq.size() == 106, "R3 back to back count", oq.size(), 106);
    chk(soc_cnt == 2 && soc_bad == 0, "R3 back to back starts", soc_cnt, 2);
    if (oq.size() == 106) begin
      chk(oq[55] == cb(8'h00, 8'h00, 8'h02, 8'h00, 8'hD2, 2), "R3 second cell order",
          oq[55], 8'h02);
      chk(oq[2] == 8'h01, "R3 first cell order", oq[2], 8'h01);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule